// File: doc/BRIEF.md
# USB Channel Event and Interrupt Mask Registers

This block collects single-cycle event pulses from a USB device channel into sticky status flags and turns them into one level-sensitive interrupt request. Software sees two 16-bit registers on a simple register bus: an event register, whose flags are cleared by writing ones, and a mask register, which selects which pending flags may drive the interrupt. Flags latch whatever the mask says, so enabling a source later while its flag is still pending raises the interrupt straight away.

Ten event sources are wired to fixed flag positions: bus reset detected, idle line status changed, a transmit error for each of four endpoints, start of frame received, busy (receive data thrown away for lack of a buffer), transmit buffer done and receive buffer done. The channel logic decides when each pulse fires, for example whether transmit buffer done fires once the final character reaches the transmit FIFO or only after it has left on the line. The block only records the pulse.

The interrupt path is a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` when any flag that is both set and enabled is seen. `IRQ_RAISED` returns to `IRQ_QUIET` once no such flag remains. Both states hold when their exit condition is absent.

Top module: `usb_evt_regs`

## Requirements
- R1: After reset the event register and the mask register both read 0x0000 and `irq` is low.
- R2: Register layout in bus bit positions, bit 0 least significant: [0] receive buffer done, [1] transmit buffer done, [2] busy, [3] start of frame, [7:4] transmit error for endpoints 4,3,2,1 (bit 4 = endpoint 1, from `ev_tx_err[0]`), [8] idle changed, [9] bus reset. Bits [15:10] always read zero in both registers.
- R3: A one-cycle pulse on a source sets its event flag at the next clock edge. The flag stays set until software clears it, and setting it does not depend on the mask.
- R4: A write to the event register clears every flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. Several flags may be cleared in one write.
- R5: If a source pulses in the same cycle as a clearing write to that flag, the flag ends up set.
- R6: The event register is at address 0xA10 and the mask register at 0xA14. A mask write stores data bits [9:0]. A read returns the selected register on `bus_rdata` in the cycle after `bus_rd`. Any other address, or no read in the previous cycle, returns zero.
- R7: `irq` rises one cycle after a flag is set whose mask bit is 1. It stays high while any such flag remains, and falls one cycle after the last one is cleared.
- R8: A pending flag whose mask bit is 0 does not raise `irq`. Setting that mask bit later raises `irq` one cycle after the mask write.
- R9: Reading the event register does not change any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_idle_chg | input | 1 | Idle line status changed pulse |
| ev_tx_err | input | 4 | Per-endpoint transmit error pulses, index 0 = endpoint 1 |
| ev_sof | input | 1 | Start of frame received pulse |
| ev_busy | input | 1 | Receive data discarded pulse |
| ev_tx_done | input | 1 | Transmit buffer done pulse |
| ev_rx_done | input | 1 | Receive buffer done pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Single-source pulses are swept one position at a time, which pins down the bit layout and shows that flags latch with the mask off. Partial clearing patterns separate write-one-to-clear from plain overwrite, and a pulse that lands together with a clear of the same flag shows which one wins. A sweep of all 1023 nonzero event patterns, each against a mask pattern derived from it arithmetically, compares `irq` with the OR of event AND mask. The same sweep then enables every source late and clears flags in two steps, which checks the rise latency, the hold while one flag remains, and the exact cycle the request falls.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

    localparam int REG_W    = 16;
    localparam int EP_N     = 4;
    localparam int SRC_N    = 6 + EP_N;

    localparam int POS_RX_DONE  = 0;
    localparam int POS_TX_DONE  = 1;
    localparam int POS_BUSY     = 2;
    localparam int POS_SOF      = 3;
    localparam int POS_TX_ERR   = 4;
    localparam int POS_IDLE     = POS_TX_ERR + EP_N;
    localparam int POS_BUS_RST  = POS_IDLE + 1;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/usb_evt_sticky.sv
module usb_evt_sticky #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_o[i] <= 1'b0;
            end else if (set_i[i]) begin
                flags_o[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flags_o[i] <= 1'b0;
            end
        end

        assert_set_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flags_o[i]);

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[i] && clr_i[i]) |=> flags_o[i]);

        assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !flags_o[i]);

        assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> (flags_o[i] == $past(flags_o[i])));
    end

endmodule

// File: rtl/usb_evt_mask.sv
module usb_evt_mask #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] mask_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (wr_i) begin
            mask_o <= wdata_i;
        end
    end

    assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_o == $past(wdata_i)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));

endmodule

// File: rtl/usb_evt_irq_fsm.sv
module usb_evt_irq_fsm
    import usb_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending_i) state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_QUIET:  irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
        endcase
    end

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pending_i |=> irq_o);

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_i |=> !irq_o);

endmodule

// File: rtl/usb_evt_regs.sv
module usb_evt_regs
    import usb_evt_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] EVT_ADDR  = 12'hA10,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 12'hA14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              ev_bus_reset,
    input  logic              ev_idle_chg,
    input  logic [3:0]        ev_tx_err,
    input  logic              ev_sof,
    input  logic              ev_busy,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    output logic              irq
);

    localparam int PAD_W = REG_W - SRC_N;

    logic [SRC_N-1:0] src_pulse;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] evt_flags;
    logic [SRC_N-1:0] mask_bits;
    logic             hit_evt;
    logic             hit_mask;
    logic             pending;
    logic             unused_wdata_hi;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        src_pulse                          = '0;
        src_pulse[POS_RX_DONE]             = ev_rx_done;
        src_pulse[POS_TX_DONE]             = ev_tx_done;
        src_pulse[POS_BUSY]                = ev_busy;
        src_pulse[POS_SOF]                 = ev_sof;
        src_pulse[POS_TX_ERR +: EP_N]      = ev_tx_err;
        src_pulse[POS_IDLE]                = ev_idle_chg;
        src_pulse[POS_BUS_RST]             = ev_bus_reset;
    end

    assign hit_evt         = (bus_addr == EVT_ADDR);
    assign hit_mask        = (bus_addr == MASK_ADDR);
    assign clr_vec         = (bus_wr && hit_evt) ? bus_wdata[SRC_N-1:0] : '0;
    assign unused_wdata_hi = &{1'b0, bus_wdata[REG_W-1:SRC_N]};

    usb_evt_sticky #(.N(SRC_N)) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_pulse),
        .clr_i   (clr_vec),
        .flags_o (evt_flags)
    );

    usb_evt_mask #(.N(SRC_N)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && hit_mask),
        .wdata_i (bus_wdata[SRC_N-1:0]),
        .mask_o  (mask_bits)
    );

    assign pending = |(evt_flags & mask_bits);

    usb_evt_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending),
        .irq_o     (irq)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_evt) begin
            rd_mux = {{PAD_W{1'b0}}, evt_flags};
        end else if (hit_mask) begin
            rd_mux = {{PAD_W{1'b0}}, mask_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[REG_W-1:SRC_N] == '0));

    assert_read_nondestructive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && (src_pulse == '0)) |=> $stable(evt_flags));

    assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_flags & mask_bits) == '0) |=> !irq);

endmodule

// File: tb/usb_evt_regs_tb.sv
module usb_evt_regs_tb;

    localparam logic [11:0] A_EVT  = 12'hA10;
    localparam logic [11:0] A_MASK = 12'hA14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [9:0]  src = '0;
    logic        irq;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    usb_evt_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .ev_bus_reset (src[9]),
        .ev_idle_chg  (src[8]),
        .ev_tx_err    (src[7:4]),
        .ev_sof       (src[3]),
        .ev_busy      (src[2]),
        .ev_tx_done   (src[1]),
        .ev_rx_done   (src[0]),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [9:0] p);
        @(negedge clk);
        src = p;
        @(negedge clk);
        src = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_EVT, d);  chk("R1 event reset", d, 16'h0000);
        rd(A_MASK, d); chk("R1 mask reset", d, 16'h0000);
        chk("R1 irq reset", {15'd0, irq}, 16'h0000);

        // R2 / R3 / R8 / R9 single-source layout sweep, mask off
        for (int i = 0; i < 10; i++) begin
            pulse(10'(1 << i));
            rd(A_EVT, d); chk("R2 R3 layout", d, 16'(1 << i));
            rd(A_EVT, d); chk("R9 read keeps flag", d, 16'(1 << i));
            chk("R8 masked no irq", {15'd0, irq}, 16'h0000);
            wr(A_EVT, 16'hFFFF);
            rd(A_EVT, d); chk("R4 clear all", d, 16'h0000);
        end

        // R6 mask access and address decode
        wr(A_MASK, 16'hFFFF);
        rd(A_MASK, d); chk("R6 R2 mask reserved zero", d, 16'h03FF);
        wr(A_MASK, 16'h1234);
        rd(A_MASK, d); chk("R6 mask store", d, 16'h0234);
        rd(12'hA18, d); chk("R6 other address", d, 16'h0000);
        @(negedge clk); chk("R6 idle rdata", bus_rdata, 16'h0000);
        wr(A_MASK, 16'h0000);

        // R4 partial clears
        pulse(10'h3FF);
        wr(A_EVT, 16'h0055);
        rd(A_EVT, d); chk("R4 partial clear", d, 16'h03AA);
        wr(A_EVT, 16'h0000);
        rd(A_EVT, d); chk("R4 zero write no effect", d, 16'h03AA);
        wr(A_EVT, 16'hFFFF);

        // R5 set wins over simultaneous clear
        @(negedge clk);
        src = 10'h008; bus_addr = A_EVT; bus_wdata = 16'h0009; bus_wr = 1'b1;
        @(negedge clk);
        src = '0; bus_wr = 1'b0;
        rd(A_EVT, d); chk("R5 set wins", d, 16'h0008);
        wr(A_EVT, 16'hFFFF);

        // R7 / R8 sweep of event patterns against derived masks
        for (int p = 1; p < 1024; p++) begin
            logic [9:0] pv;
            logic [9:0] qv;
            logic [9:0] lsb;
            pv  = p[9:0];
            qv  = 10'((p * 37 + 11) & 32'h3FF);
            lsb = pv & (~pv + 10'd1);
            wr(A_MASK, {6'd0, qv});
            pulse(pv);
            @(negedge clk);
            chk("R7 R8 irq equals OR of event AND mask", {15'd0, irq}, {15'd0, |(pv & qv)});
            wr(A_MASK, 16'h03FF);
            @(negedge clk);
            chk("R8 late enable raises irq", {15'd0, irq}, 16'h0001);
            wr(A_EVT, {6'd0, pv & ~lsb});
            @(negedge clk);
            chk("R7 irq holds while one remains", {15'd0, irq}, 16'h0001);
            wr(A_EVT, {6'd0, lsb});
            chk("R7 irq one-cycle fall lag", {15'd0, irq}, 16'h0001);
            @(negedge clk);
            chk("R7 irq falls after last clear", {15'd0, irq}, 16'h0000);
        end

        rd(A_EVT, d); chk("R4 all flags cleared at end", d, 16'h0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule